// File: doc/BRIEF.md
# Banked Configuration Switch Window

This block is an I/O-mapped store for configuration switches that software can set. It keeps 24 bytes arranged as two banks of twelve. Twelve small windows of four addresses each, spaced 256 addresses apart, give access to the store. The address high byte picks the window. Only one byte offset inside a window carries data.

A read or write at that data offset reaches one entry. The window number gives the position within the bank, and a bank register gives the bank. The bank register is loaded by a write to a control offset of the last window, and software cannot read it back. The block sits on a simple synchronous 8-bit I/O bus. It raises a hit flag whenever the address lies inside any window, so that an outer bus multiplexer can choose this block's read data.

Top module: `swcfg_window`

## Requirements
- R1: After reset the bank register is 0, every one of the 24 entries holds the RESET_VAL parameter, and the read data output is 0xFF.
- R2: `io_hit` is high in the same cycle, with no clock edge, exactly when `io_addr` lies in 0x841C + n*0x100 up to 0x841F + n*0x100 for some n in 0..11. At most one window matches.
- R3: A read strobe at offset 2 of window n (address 0x841E + n*0x100) puts entry n + 12*bank on `io_rdata` at the next rising clock edge.
- R4: A write strobe at offset 2 of window n stores `io_wdata` into entry n + 12*bank.
- R5: A read strobe at offset 0, 1 or 3 of any window, or at an address outside every window, returns 0xFF. Offset 3 of window 11 also reads 0xFF, so the bank register is write-only.
- R6: A write strobe at offset 0, 1 or 3 of any window, or outside every window, changes no entry.
- R7: A write strobe at 0x8F1F loads the bank register from bit 6 of `io_wdata`. The other data bits have no effect. No other write changes the bank.
- R8: A write strobe at 0x8F1E stores into entry 11 + 12*bank, using the bank in effect before that write. Its data bit 6 does not change the bank.
- R9: `io_rdata` keeps its value in every cycle without a read strobe. A read and a write in the same cycle return the entry value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| io_hit | output | 1 | Address lies inside one of the twelve windows |

## Verification
The hit flag is combinational. The bench checks it one time unit after it drives a new address, with no clock edge in between. Read data is due at the first rising edge after the read strobe. Entry and bank updates take effect at the edge that samples the write strobe. The bench drives every strobe on a falling edge, removes it on the next falling edge, and samples `io_rdata` at that same falling edge, half a cycle after the edge that registered it. A bank change is checked only through the data that later reads return.

// File: rtl/swcfg_pkg.sv
package swcfg_pkg;

  // Byte offsets inside one four-address window
  typedef enum logic [1:0] {
    OFS_RSV0 = 2'd0,
    OFS_RSV1 = 2'd1,
    OFS_DATA = 2'd2,
    OFS_CTRL = 2'd3
  } win_ofs_e;

  localparam logic [7:0] IDLE_READ = 8'hFF;

endpackage

// File: rtl/swcfg_decode.sv
module swcfg_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned N_WIN     = 12,
  parameter int unsigned BASE      = 'h841C,
  parameter int unsigned STRIDE    = 'h0100,
  localparam int unsigned WIN_IDX_W = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [N_WIN-1:0]     win_sel,
  output logic [WIN_IDX_W-1:0] win_idx,
  output swcfg_pkg::win_ofs_e  ofs,
  output logic                 hit
);

  // One comparator per window on the address bits above the 2-bit offset
  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(BASE + g * STRIDE);
    assign win_sel[g] = (addr[ADDR_W-1:2] == WIN_BASE[ADDR_W-1:2]);
  end

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N_WIN; i++) begin
      if (win_sel[i]) win_idx = WIN_IDX_W'(i);
    end
  end

  assign ofs = swcfg_pkg::win_ofs_e'(addr[1:0]);
  assign hit = |win_sel;

endmodule

// File: rtl/swcfg_store.sv
module swcfg_store #(
  parameter int unsigned N_WIN     = 12,
  parameter int unsigned N_BANK    = 2,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BANK_BIT  = 6,
  parameter logic [DATA_W-1:0] RESET_VAL = '0,
  localparam int unsigned N_ENT     = N_WIN * N_BANK,
  localparam int unsigned WIN_IDX_W = (N_WIN > 1) ? $clog2(N_WIN) : 1,
  localparam int unsigned BANK_W    = (N_BANK > 1) ? $clog2(N_BANK) : 1,
  localparam int unsigned ENT_IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_data_en,
  input  logic                 wr_bank_en,
  input  logic [WIN_IDX_W-1:0] win_idx,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rd_entry
);

  logic [BANK_W-1:0]              bank_q, bank_d;
  logic [N_ENT-1:0][DATA_W-1:0]   mem_q, mem_d;
  logic [N_ENT-1:0]               ent_we;
  logic [ENT_IDX_W-1:0]           ent_idx;

  // Entry index: position in bank plus bank offset; old bank applies
  assign ent_idx = ENT_IDX_W'(ENT_IDX_W'(bank_q) * ENT_IDX_W'(N_WIN))
                 + ENT_IDX_W'(win_idx);

  assign bank_d = wr_bank_en ? wdata[BANK_BIT +: BANK_W] : bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    assign ent_we[e] = wr_data_en && (ent_idx == ENT_IDX_W'(e));
    assign mem_d[e]  = ent_we[e] ? wdata : mem_q[e];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[e] <= RESET_VAL;
      else        mem_q[e] <= mem_d[e];
    end
  end

  assign rd_entry = mem_q[ent_idx];

  // R7: the bank register moves only on a bank-control write
  p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_bank_en |=> $stable(bank_q));

  // R6: no entry changes without a data-offset write
  p_entry_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data_en |=> $stable(mem_q));

  // R4: a data write leaves its value in the addressed entry
  p_entry_written_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_en |=> (mem_q[$past(ent_idx)] == $past(wdata)));

endmodule

// File: rtl/swcfg_window.sv
module swcfg_window #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned N_WIN     = 12,
  parameter int unsigned N_BANK    = 2,
  parameter int unsigned BASE      = 'h841C,
  parameter int unsigned STRIDE    = 'h0100,
  parameter int unsigned BANK_BIT  = 6,
  parameter logic [DATA_W-1:0] RESET_VAL = '0,
  localparam int unsigned WIN_IDX_W = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_hit
);
  import swcfg_pkg::*;

  localparam logic [DATA_W-1:0] MISS_VAL = DATA_W'(IDLE_READ);

  logic [N_WIN-1:0]     win_sel;
  logic [WIN_IDX_W-1:0] win_idx;
  win_ofs_e             ofs;
  logic                 hit;
  logic                 wr_data_en, wr_bank_en, rd_data_sel;
  logic [DATA_W-1:0]    rd_entry;
  logic [DATA_W-1:0]    rdata_q, rdata_d;

  swcfg_decode #(
    .ADDR_W (ADDR_W),
    .N_WIN  (N_WIN),
    .BASE   (BASE),
    .STRIDE (STRIDE)
  ) i_decode (
    .addr    (io_addr),
    .win_sel (win_sel),
    .win_idx (win_idx),
    .ofs     (ofs),
    .hit     (hit)
  );

  assign wr_data_en  = io_wr && hit && (ofs == OFS_DATA);
  assign wr_bank_en  = io_wr && win_sel[N_WIN-1] && (ofs == OFS_CTRL);
  assign rd_data_sel = hit && (ofs == OFS_DATA);

  swcfg_store #(
    .N_WIN     (N_WIN),
    .N_BANK    (N_BANK),
    .DATA_W    (DATA_W),
    .BANK_BIT  (BANK_BIT),
    .RESET_VAL (RESET_VAL)
  ) i_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_data_en (wr_data_en),
    .wr_bank_en (wr_bank_en),
    .win_idx    (win_idx),
    .wdata      (io_wdata),
    .rd_entry   (rd_entry)
  );

  // Read register: loads on the strobe, holds otherwise
  always_comb begin
    rdata_d = rdata_q;
    if (io_rd) rdata_d = rd_data_sel ? rd_entry : MISS_VAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= MISS_VAL;
    else        rdata_q <= rdata_d;
  end

  assign io_rdata = rdata_q;
  assign io_hit   = hit;

  // R2: window comparators never overlap
  p_one_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_sel));

  // R5: a read that misses the data offset returns the idle byte
  p_miss_reads_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !rd_data_sel) |=> (io_rdata == MISS_VAL));

  // R9: read data is held without a strobe
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

endmodule

// File: tb/test_swcfg_window.sv
module test_swcfg_window;

  localparam int CLK_P = 10;
  localparam logic [7:0] RST_V = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_rd, io_wr;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        io_hit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] model [24];
  int         mbank;

  always #(CLK_P/2) clk = ~clk;

  swcfg_window #(.RESET_VAL(RST_V)) i_swcfg_window (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wadr(input int n, input int ofs);
    return 16'h841C + 16'(n * 'h100) + 16'(ofs);
  endfunction

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 rdata after reset", io_rdata, 8'hFF);
    for (int n = 0; n < 12; n++) begin
      bus_rd(wadr(n, 2), d);
      check("R1 bank0 default", d, RST_V);
    end
    bus_wr(16'h8F1F, 8'h40); mbank = 1;
    for (int n = 0; n < 12; n++) begin
      bus_rd(wadr(n, 2), d);
      check("R1 bank1 default", d, RST_V);
    end
    bus_wr(16'h8F1F, 8'h00); mbank = 0;
  endtask

  task automatic t_decode;
    logic [15:0] a;
    for (int n = 0; n < 12; n++) begin
      for (int o = 0; o < 4; o++) begin
        @(negedge clk); io_addr = wadr(n, o); #1;
        check("R2 hit inside window", {7'd0, io_hit}, 8'd1);
      end
    end
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: a = 16'h841B; 1: a = 16'h8420; 2: a = 16'h901C;
        3: a = 16'h831F; 4: a = 16'h0000; default: a = 16'h851B;
      endcase
      @(negedge clk); io_addr = a; #1;
      check("R2 no hit outside", {7'd0, io_hit}, 8'd0);
    end
  endtask

  task automatic t_rw_banks;
    logic [7:0] d;
    for (int b = 0; b < 2; b++) begin
      bus_wr(16'h8F1F, b[0] ? 8'h40 : 8'h00); mbank = b;
      for (int n = 0; n < 12; n++) begin
        model[n + 12*b] = 8'(8'h10 * b + n * 7 + 3);
        bus_wr(wadr(n, 2), model[n + 12*b]);
      end
    end
    for (int b = 0; b < 2; b++) begin
      bus_wr(16'h8F1F, b[0] ? 8'hC0 : 8'hBF); mbank = b;
      for (int n = 0; n < 12; n++) begin
        bus_rd(wadr(n, 2), d);
        check("R3 R4 R7 entry readback", d, model[n + 12*b]);
      end
    end
  endtask

  task automatic t_offsets;
    logic [7:0] d;
    for (int n = 0; n < 12; n++) begin
      for (int o = 0; o < 4; o++) begin
        if (o == 2) continue;
        bus_rd(wadr(n, o), d);
        check("R5 non-data offset reads FF", d, 8'hFF);
        if (!(n == 11 && o == 3)) bus_wr(wadr(n, o), 8'hE7);
      end
    end
    bus_rd(16'h8F1F, d);
    check("R5 bank bit write-only", d, 8'hFF);
    bus_wr(16'h1234, 8'h99);
    bus_rd(16'h1234, d);
    check("R5 miss reads FF", d, 8'hFF);
    for (int n = 0; n < 12; n++) begin
      bus_rd(wadr(n, 2), d);
      check("R6 entries unchanged", d, model[n + 12*mbank]);
    end
  endtask

  task automatic t_last_window;
    logic [7:0] d;
    bus_wr(16'h8F1F, 8'h00); mbank = 0;
    bus_wr(16'h8F1E, 8'h40); model[11] = 8'h40;
    bus_rd(16'h841E, d);
    check("R8 offset2 write leaves bank 0", d, model[0]);
    bus_wr(16'h8F1F, 8'h40); mbank = 1;
    bus_rd(16'h8F1E, d);
    check("R8 bank1 entry 23 intact", d, model[23]);
    bus_wr(16'h8F1F, 8'h00); mbank = 0;
    bus_rd(16'h8F1E, d);
    check("R8 entry 11 written in bank0", d, 8'h40);
  endtask

  task automatic t_hold;
    logic [7:0] d;
    bus_rd(wadr(3, 2), d);
    repeat (3) @(negedge clk);
    check("R9 rdata held", io_rdata, model[3]);
    @(negedge clk);
    io_addr = wadr(3, 2); io_wdata = 8'hA5; io_rd = 1'b1; io_wr = 1'b1;
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0;
    check("R9 read beside write returns old", io_rdata, model[3]);
    model[3] = 8'hA5;
    bus_rd(wadr(3, 2), d);
    check("R9 R4 simultaneous write landed", d, 8'hA5);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    rst_n = 1'b0; io_addr = '0; io_rd = 1'b0; io_wr = 1'b0; io_wdata = '0;
    mbank = 0;
    for (int i = 0; i < 24; i++) model[i] = RST_V;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_rw_banks();
    t_offsets();
    t_last_window();
    t_hold();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule